// File: doc/BRIEF.md
# Two-Port Banked Data Memory with Conflict Stall

This block holds the internal data RAM shared by two parallel access ports, A and B. The RAM is divided into several single-ported banks, interleaved on 8-byte words. Each cycle each port may present one access: a load or a store with a byte address, 64-bit write data and eight byte enables. If the two accesses fall in different banks, both are performed in that cycle. If they fall in the same bank, only one can be performed, so the block raises a stall for one cycle and performs the other access in the next cycle.

Port A is treated as the earlier access in program order. In a same-bank collision A is always performed first and B second. This fixes the outcome when both touch the same word: a load on A paired with a store on B sees the old contents, and a store on A paired with a load on B sees the new contents. The surrounding pipeline must hold both requests unchanged for the cycle after a stall. Load data appears on the port's read bus one cycle after the load is performed.

Top module: `banked_mem_arbiter`

## Requirements
- R1: The bank of an access is byte-address bits [4:3] (with the default of four banks) and the row is the address bits above them. Address bits [2:0] do not select anything.
- R2: When both ports request and their banks differ, both accesses are performed in the same cycle and stall stays low.
- R3: When both ports request the same bank, stall is high in that cycle, only port A is performed, and stall never stays high for two cycles in a row.
- R4: In the cycle after a stall, with the requests held, port B's access is performed and stall is low.
- R5: The data of a load appears on that port's read bus in the cycle right after the load is performed.
- R6: A load on port A that collides with a store on port B to the same word returns the contents from before the store.
- R7: A store on port A that collides with a load on port B to the same word is visible to that load.
- R8: On a store, byte enable bit k writes data bits [8k+7:8k] and leaves the other bytes of the word unchanged.
- R9: A port whose request input is low performs no access, even with its write flag set, and cannot cause a stall.
- R10: After reset, stall is low and both read buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Port A access request |
| a_we | input | 1 | Port A store (1) or load (0) |
| a_addr | input | 10 | Port A byte address |
| a_wdata | input | 64 | Port A store data |
| a_be | input | 8 | Port A byte enables |
| a_rdata | output | 64 | Port A load data |
| b_req | input | 1 | Port B access request |
| b_we | input | 1 | Port B store (1) or load (0) |
| b_addr | input | 10 | Port B byte address |
| b_wdata | input | 64 | Port B store data |
| b_be | input | 8 | Port B byte enables |
| b_rdata | output | 64 | Port B load data |
| stall | output | 1 | Same-bank collision: hold both requests one more cycle |

## Verification
The stall output is combinational on the current requests, so the bench checks it one time unit after driving inputs, in the same cycle. A load performed at a clock edge must show its data at the next sampling point, half a cycle after that edge. For a collision, A's data is therefore due one cycle after the request first appears and B's data two cycles after it. The bench's behavioural memory model applies A before B and computes each expected word when the access is performed, then compares it at exactly that due cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 8;
    localparam int OFFS_BITS  = 3;

    typedef struct packed {
        logic second_half;
    } ctrl_state_t;
endpackage

// File: rtl/bank_ram.sv
module bank_ram #(
    parameter int DATA_W = 64,
    parameter int ROWS   = 32,
    localparam int ROW_BITS = $clog2(ROWS),
    localparam int NBYTES   = DATA_W / arb_pkg::BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                we,
    input  logic [ROW_BITS-1:0] row,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NBYTES-1:0]   be,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (en && !we) rdata_d = mem[row];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NBYTES; k++) begin
            if (en && we && be[k])
                mem[row][k*arb_pkg::BYTE_W +: arb_pkg::BYTE_W] <= wdata[k*arb_pkg::BYTE_W +: arb_pkg::BYTE_W];
        end
    end

    assign rdata = rdata_q;

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && !we) |=> $stable(rdata)); // R5
endmodule

// File: rtl/conflict_ctrl.sv
module conflict_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic a_req,
    input  logic b_req,
    input  logic same_bank,
    output logic grant_a,
    output logic grant_b,
    output logic stall
);
    import arb_pkg::*;

    ctrl_state_t st_d, st_q;
    logic        collide;

    always_comb begin
        collide          = a_req && b_req && same_bank;
        st_d             = st_q;
        st_d.second_half = collide && !st_q.second_half;
        stall            = collide && !st_q.second_half;
        grant_a          = a_req && !st_q.second_half;
        grant_b          = b_req && (!collide || st_q.second_half);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall); // R3
    AST_STALL_SERVES_A: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (grant_a && !grant_b)); // R3
    AST_B_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (!b_req || grant_b)); // R4
    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_req |-> !grant_a) and (!b_req |-> !grant_b)); // R9
endmodule

// File: rtl/banked_mem_arbiter.sv
module banked_mem_arbiter #(
    parameter int ADDR_W    = 10,
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 64,
    localparam int BANK_BITS = $clog2(NUM_BANKS),
    localparam int ROW_BITS  = ADDR_W - arb_pkg::OFFS_BITS - BANK_BITS,
    localparam int ROWS      = 1 << ROW_BITS,
    localparam int NBYTES    = DATA_W / arb_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic [NBYTES-1:0] a_be,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_req,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic [NBYTES-1:0] b_be,
    output logic [DATA_W-1:0] b_rdata,
    output logic              stall
);
    import arb_pkg::*;

    typedef struct packed {
        logic [BANK_BITS-1:0] a_bank;
        logic [BANK_BITS-1:0] b_bank;
    } track_t;

    logic [BANK_BITS-1:0] a_bank, b_bank;
    logic [ROW_BITS-1:0]  a_row, b_row;
    logic                 grant_a, grant_b;
    logic [DATA_W-1:0]    bank_rd [NUM_BANKS];
    track_t               trk_d, trk_q;

    assign a_bank = a_addr[OFFS_BITS +: BANK_BITS];
    assign b_bank = b_addr[OFFS_BITS +: BANK_BITS];
    assign a_row  = a_addr[OFFS_BITS + BANK_BITS +: ROW_BITS];
    assign b_row  = b_addr[OFFS_BITS + BANK_BITS +: ROW_BITS];

    conflict_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_req     (a_req),
        .b_req     (b_req),
        .same_bank (a_bank == b_bank),
        .grant_a   (grant_a),
        .grant_b   (grant_b),
        .stall     (stall)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic              hit_a, hit_b, en, we;
        logic [ROW_BITS-1:0] row;
        logic [DATA_W-1:0] wdata;
        logic [NBYTES-1:0] be;

        always_comb begin
            hit_a = grant_a && (a_bank == BANK_BITS'(i));
            hit_b = grant_b && (b_bank == BANK_BITS'(i));
            en    = hit_a || hit_b;
            we    = hit_a ? a_we    : b_we;
            row   = hit_a ? a_row   : b_row;
            wdata = hit_a ? a_wdata : b_wdata;
            be    = hit_a ? a_be    : b_be;
        end

        bank_ram #(.DATA_W(DATA_W), .ROWS(ROWS)) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .we    (we),
            .row   (row),
            .wdata (wdata),
            .be    (be),
            .rdata (bank_rd[i])
        );

        AST_BANK_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
            !(hit_a && hit_b)); // R2
    end

    always_comb begin
        trk_d = trk_q;
        if (grant_a) trk_d.a_bank = a_bank;
        if (grant_b) trk_d.b_bank = b_bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign a_rdata = bank_rd[trk_q.a_bank];
    assign b_rdata = bank_rd[trk_q.b_bank];

    AST_STALL_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (a_req && b_req && a_bank == b_bank)); // R3
    AST_SPLIT_BANKS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && b_req && a_bank != b_bank) |-> (!stall && grant_a && grant_b)); // R2
endmodule

// File: tb/sim_banked_mem_arbiter.sv
module sim_banked_mem_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_req = 1'b0, a_we = 1'b0, b_req = 1'b0, b_we = 1'b0;
    logic [9:0]  a_addr = '0, b_addr = '0;
    logic [63:0] a_wdata = '0, b_wdata = '0;
    logic [7:0]  a_be = '0, b_be = '0;
    logic [63:0] a_rdata, b_rdata;
    logic        stall;

    int checks = 0;
    int errors = 0;
    logic [63:0] model [WORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_mem_arbiter u0 (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_be(a_be), .a_rdata(a_rdata),
        .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_be(b_be), .b_rdata(b_rdata),
        .stall(stall)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", rq, what, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] d, input logic [7:0] be);
        logic [63:0] r = old;
        for (int k = 0; k < 8; k++) if (be[k]) r[k*8 +: 8] = d[k*8 +: 8];
        return r;
    endfunction

    // One access pair; holds the requests for a second cycle on a collision.
    task automatic step(input logic ar, input logic aw, input logic [9:0] aa, input logic [63:0] ad, input logic [7:0] abe,
                        input logic br, input logic bw, input logic [9:0] ba, input logic [63:0] bd, input logic [7:0] bbe,
                        input string rq);
        logic [6:0]  wa, wb;
        logic        conf;
        logic [63:0] ea, eb;
        a_req = ar; a_we = aw; a_addr = aa; a_wdata = ad; a_be = abe;
        b_req = br; b_we = bw; b_addr = ba; b_wdata = bd; b_be = bbe;
        #1;
        wa = aa[9:3]; wb = ba[9:3];
        conf = ar && br && (wa[1:0] == wb[1:0]);
        chk(stall === conf, rq, "stall", {63'd0, stall}, {63'd0, conf});
        ea = '0; eb = '0;
        if (ar) begin
            if (aw) model[wa] = merge(model[wa], ad, abe);
            else    ea = model[wa];
        end
        if (br && !conf) begin
            if (bw) model[wb] = merge(model[wb], bd, bbe);
            else    eb = model[wb];
        end
        @(posedge clk); @(negedge clk);
        if (ar && !aw) chk(a_rdata === ea, rq, "a_rdata", a_rdata, ea);
        if (br && !conf && !bw) chk(b_rdata === eb, rq, "b_rdata", b_rdata, eb);
        if (conf) begin
            #1;
            chk(stall === 1'b0, {rq, " R4"}, "stall second cycle", {63'd0, stall}, 64'd0);
            if (bw) model[wb] = merge(model[wb], bd, bbe);
            else    eb = model[wb];
            @(posedge clk); @(negedge clk);
            if (!bw) chk(b_rdata === eb, {rq, " R4"}, "b_rdata after collision", b_rdata, eb);
        end
        a_req = 1'b0; b_req = 1'b0;
    endtask

    function automatic logic [9:0] adr(input int word, input int low);
        return 10'((word << 3) | (low & 7));
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        #1;
        chk(stall === 1'b0, "R10", "stall in reset", {63'd0, stall}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stall === 1'b0, "R10", "stall after reset", {63'd0, stall}, 64'd0);
        chk(a_rdata === 64'd0, "R10", "a_rdata after reset", a_rdata, 64'd0);
        chk(b_rdata === 64'd0, "R10", "b_rdata after reset", b_rdata, 64'd0);

        // Preload every word, pairs of adjacent words sit in different banks (R2)
        for (int i = 0; i < WORDS; i += 2)
            step(1, 1, adr(i, 0), {32'hA5A5_0000, 32'(i)}, 8'hFF,
                 1, 1, adr(i + 1, 0), {32'h5A5A_0000, 32'(i + 1)}, 8'hFF, "R2 preload");

        // R1 R2 R5: parallel loads, different banks, nonzero offset bits
        step(1, 0, adr(5, 7), '0, '0, 1, 0, adr(6, 3), '0, '0, "R1 R2 R5");
        step(1, 0, adr(40, 1), '0, '0, 1, 0, adr(43, 6), '0, '0, "R2 R5");
        // R1 R3: same bank, different rows (words 4 and 8 both bank 0)
        step(1, 0, adr(4, 0), '0, '0, 1, 0, adr(8, 5), '0, '0, "R1 R3");
        // R6: A load then B store, same word
        step(1, 0, adr(9, 0), '0, '0, 1, 1, adr(9, 2), 64'hDEAD_BEEF_0BAD_F00D, 8'hFF, "R6 R3");
        step(1, 0, adr(9, 0), '0, '0, 0, 0, '0, '0, '0, "R6 readback");
        // R7: A store then B load, same word
        step(1, 1, adr(17, 0), 64'h1122_3344_5566_7788, 8'hFF, 1, 0, adr(17, 4), '0, '0, "R7 R3");
        // R8: partial byte enables
        step(0, 0, '0, '0, '0, 1, 1, adr(30, 0), 64'hFFFF_FFFF_FFFF_FFFF, 8'b1010_0101, "R8 store");
        step(1, 0, adr(30, 0), '0, '0, 0, 0, '0, '0, '0, "R8 load");
        step(1, 1, adr(31, 0), 64'h0, 8'b0000_0001, 0, 0, '0, '0, '0, "R8 store A");
        step(0, 0, '0, '0, '0, 1, 0, adr(31, 0), '0, '0, "R8 load B");
        // R9: request low with write flag set has no effect and no stall
        step(1, 0, adr(12, 0), '0, '0, 0, 1, adr(12, 0), 64'h0123_4567_89AB_CDEF, 8'hFF, "R9");
        step(0, 1, adr(50, 0), 64'h77, 8'hFF, 1, 0, adr(50, 0), '0, '0, "R9");
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [9:0]  ra, rb;
            logic [63:0] da, db;
            ra = 10'($urandom); rb = ($urandom % 3 == 0) ? ra : 10'($urandom);
            da = {$urandom, $urandom}; db = {$urandom, $urandom};
            step(1'($urandom), 1'($urandom), ra, da, 8'($urandom),
                 1'($urandom), 1'($urandom), rb, db, 8'($urandom), "R1 R3 R5 R8 random");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule